// File: doc/BRIEF.md
# Clause-22 Management Frame Controller

This block is the host end of an IEEE 802.3 clause-22 management link. Software writes one complete 32-bit frame word (start, opcode, PHY address, register address, turnaround and data) into the command/data register. The controller then sends 32 preamble ones followed by that word, most significant bit first, on a serial clock and data pair. For a read opcode it releases the data line after the header and shifts the 16 reply bits into the low half of the same register.

The serial clock comes from a programmable divider. Its half period is the speed field in system clock cycles. A speed of zero keeps the serial clock parked low and blocks new frames. When a frame ends, a sticky completion event is raised, and software clears it by writing a one to it. A small word-wide register port gives access to the command/data word, the speed field and the event register.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, the command/data, speed and event registers all read 0, the serial clock is low and the data line is released (output enable low). Address 3 always reads 0.
- R2: The speed field sits at bits 6:1 of register address 1. Bit 0 and the bits above 6 read 0. While a frame runs, each serial clock level lasts exactly speed-field cycles, so the period is twice the field.
- R3: A command write (address 0) while the speed field is 0 stores the word but starts no frame, and the serial clock stays low.
- R4: A command write while idle with a nonzero speed starts a frame of 32 ones followed by the 32-bit word, MSB first. Each bit changes on a serial clock falling edge.
- R5: When bits 29:28 of the word are 2'b10 (read), the output enable drops from frame bit 46 on, which covers turnaround and data (word bits 17:0).
- R6: In a read, the input is sampled on the serial clock rising edge of each of the last 16 frame bits and shifted into bits 15:0 MSB first. Bits 31:16 keep their written value.
- R7: The frame ends 128 times the speed field cycles after the start edge. The event bit 23 of address 2 is set on that edge and stays set until cleared.
- R8: Writing address 2 with bit 23 set clears the event. Writing it with bit 23 clear has no effect.
- R9: A command write while a frame runs is ignored. A speed write during a frame updates the register but leaves the current frame's timing unchanged.
- R10: For any opcode other than 2'b10, the data line is driven for all 64 bits. Between frames, output enable and serial clock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command/data, 1 speed, 2 event, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mgmt_clk | output | 1 | Serial management clock |
| mgmt_dout | output | 1 | Serial data out |
| mgmt_oe | output | 1 | Serial data output enable |
| mgmt_din | input | 1 | Serial data in from the PHY side |

## Verification
The frame path is exercised with write, read and non-standard opcodes at half periods of 1, 2, 3, 5 and 63 cycles. The varied periods separate divider errors from bit-ordering errors, and the opcodes show whether the line release is tied to the read opcode alone. Read replies use asymmetric patterns with set end bits, such as 0xC3A5 and 0x8001, which expose capture-edge and shift-direction faults. Back-to-back frames, command and speed writes mid-frame, a zero speed, and write-zero and write-one on the event bit check the start-blocking and sticky-event rules.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_SPD  = 2'd1,
    SEL_EVT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [1:0] OPC_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SPD_W-1:0] half,
  output logic             mgmt_clk,
  output logic             rise,
  output logic             fall
);
  localparam logic [SPD_W-1:0] ONE = SPD_W'(1);

  logic [SPD_W-1:0] cnt_q, cnt_d;
  logic             clk_d;
  logic             tick;

  always_comb begin
    tick  = run && (cnt_q == (half - ONE));
    cnt_d = cnt_q;
    clk_d = mgmt_clk;
    if (!run) begin
      cnt_d = '0;
      clk_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      clk_d = ~mgmt_clk;
    end else begin
      cnt_d = cnt_q + ONE;
    end
    rise = tick && !mgmt_clk;
    fall = tick && mgmt_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      mgmt_clk <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      mgmt_clk <= clk_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq import mdio_pkg::*; #(
  parameter int PRE_LEN = 32,
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16,
  parameter int HDR_W   = 14,
  parameter int CNT_W   = $clog2(PRE_LEN + CMD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rise,
  input  logic             fall,
  input  logic [CMD_W-1:0] cmd,
  output logic             busy,
  output logic             done,
  output logic             cap_en,
  output logic             mgmt_dout,
  output logic             mgmt_oe
);
  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int IDX_W     = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] REL_POS = CNT_W'(PRE_LEN + HDR_W);
  localparam logic [CNT_W-1:0] CAP_POS = CNT_W'(FRAME_LEN - DATA_W);

  logic             busy_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             is_read;
  logic [IDX_W-1:0] idx;

  always_comb begin
    is_read = (cmd[CMD_W-3 -: 2] == OPC_READ);
    done    = busy && fall && (pos_q == LAST);
    busy_d  = busy;
    pos_d   = pos_q;
    if (!busy) begin
      if (start) begin
        busy_d = 1'b1;
        pos_d  = '0;
      end
    end else if (fall) begin
      if (pos_q == LAST) busy_d = 1'b0;
      else               pos_d  = pos_q + CNT_W'(1);
    end
    idx       = IDX_W'(CMD_W - 1) - IDX_W'(pos_q - PRE_END);
    cap_en    = busy && rise && is_read && (pos_q >= CAP_POS);
    mgmt_oe   = busy && !(is_read && (pos_q >= REL_POS));
    if (!busy)                mgmt_dout = 1'b0;
    else if (pos_q < PRE_END) mgmt_dout = 1'b1;
    else                      mgmt_dout = cmd[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pos_q <= '0;
    end else begin
      busy  <= busy_d;
      pos_q <= pos_d;
    end
  end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl import mdio_pkg::*; #(
  parameter int SPD_W   = 6,
  parameter int PRE_LEN = 32,
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16,
  parameter int HDR_W   = 14,
  parameter int EVT_BIT = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CMD_W-1:0] reg_wdata,
  output logic [CMD_W-1:0] reg_rdata,
  output logic             mgmt_clk,
  output logic             mgmt_dout,
  output logic             mgmt_oe,
  input  logic             mgmt_din
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [SPD_W-1:0] spd_q, spd_d, half_q, half_d;
  logic             ev_q, ev_d;
  logic             busy, done, cap_en, rise, fall;
  logic             wr_cmd, wr_spd, clr_ev, start;
  reg_sel_e         sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    sel    = reg_sel_e'(reg_addr);
    wr_cmd = reg_we && (sel == SEL_CMD) && !busy;
    wr_spd = reg_we && (sel == SEL_SPD);
    clr_ev = reg_we && (sel == SEL_EVT) && reg_wdata[EVT_BIT];
    start  = wr_cmd && (spd_q != '0);

    cmd_d = cmd_q;
    if (wr_cmd)      cmd_d = reg_wdata;
    else if (cap_en) cmd_d[DATA_W-1:0] = {cmd_q[DATA_W-2:0], mgmt_din};

    spd_d  = wr_spd ? reg_wdata[SPD_W:1] : spd_q;
    half_d = start ? spd_q : half_q;

    if (done)        ev_d = 1'b1;
    else if (clr_ev) ev_d = 1'b0;
    else             ev_d = ev_q;

    reg_rdata = '0;
    case (sel)
      SEL_CMD: reg_rdata = cmd_q;
      SEL_SPD: reg_rdata[SPD_W:1] = spd_q;
      SEL_EVT: reg_rdata[EVT_BIT] = ev_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q  <= '0;
      spd_q  <= '0;
      half_q <= '0;
      ev_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      spd_q  <= spd_d;
      half_q <= half_d;
      ev_q   <= ev_d;
    end
  end

  mdio_clkdiv #(.SPD_W(SPD_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (busy),
    .half     (half_q),
    .mgmt_clk (mgmt_clk),
    .rise     (rise),
    .fall     (fall)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN),
    .CMD_W   (CMD_W),
    .DATA_W  (DATA_W),
    .HDR_W   (HDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .rise      (rise),
    .fall      (fall),
    .cmd       (cmd_q),
    .busy      (busy),
    .done      (done),
    .cap_en    (cap_en),
    .mgmt_dout (mgmt_dout),
    .mgmt_oe   (mgmt_oe)
  );
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
  parameter int SPD_W   = 6,
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16,
  parameter int EVT_BIT = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             ev,
  input logic [SPD_W-1:0] spd,
  input logic [CMD_W-1:0] cmd,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CMD_W-1:0] reg_wdata,
  input logic             mgmt_clk,
  input logic             mgmt_oe
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mgmt_oe && !mgmt_clk));

  a_r3_zero_speed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && !busy && spd == '0) |=> !busy);

  a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 2'd0) |=> $stable(cmd[CMD_W-1:DATA_W]));

  a_r8_event_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && reg_wdata[EVT_BIT] && !done) |=> !ev);

  a_r7_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !(reg_we && reg_addr == 2'd2 && reg_wdata[EVT_BIT])) |=> ev);

  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ev && !busy));

  a_r2_clock_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgmt_clk) |-> busy);
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(
  .SPD_W   (SPD_W),
  .CMD_W   (CMD_W),
  .DATA_W  (DATA_W),
  .EVT_BIT (EVT_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .done      (done),
  .ev        (ev_q),
  .spd       (spd_q),
  .cmd       (cmd_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mgmt_clk  (mgmt_clk),
  .mgmt_oe   (mgmt_oe)
);

// File: tb/mdio_frame_ctrl_test.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        mck, mdo, moe;
  logic        mdi = 1'b0;

  always #2 clk = ~clk;

  mdio_frame_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .mgmt_clk(mck),
    .mgmt_dout(mdo), .mgmt_oe(moe), .mgmt_din(mdi)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural reference state
  bit          m_busy, m_rd, m_ev;
  int          m_t, m_h, m_spd;
  logic [31:0] m_cmd;
  logic [15:0] phy_data = 16'h0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    int j, q;
    bit done_now, was_busy;
    if (!rst_n) begin
      m_busy = 0; m_rd = 0; m_ev = 0; m_t = 0; m_h = 0; m_spd = 0; m_cmd = 32'd0;
    end else begin
      done_now = 0;
      was_busy = m_busy;
      if (m_busy) begin
        j = m_t + 1;
        if (j % m_h == 0) begin
          q = j / m_h;
          if (q % 2 == 1) begin
            if (m_rd && (q - 1) / 2 >= 48) m_cmd[15:0] = {m_cmd[14:0], mdi};
          end else if (q == 128) begin
            done_now = 1;
          end
        end
        m_t = j;
      end
      if (we && addr == 2'd2 && wdata[23]) m_ev = 0;
      if (done_now) begin m_ev = 1; m_busy = 0; end
      if (we && addr == 2'd0 && !was_busy) begin
        m_cmd = wdata;
        if (m_spd != 0) begin
          m_busy = 1; m_t = 0; m_h = m_spd; m_rd = (wdata[29:28] == 2'b10);
        end
      end
      if (we && addr == 2'd1) m_spd = int'(wdata[6:1]);
    end
  end

  always @(negedge clk) begin : compare
    int p, b;
    logic e_ck, e_oe;
    if (m_busy) begin
      p = m_t / m_h; b = p / 2;
      e_ck = (p % 2 == 1); e_oe = !(m_rd && b >= 46);
      mdi = (b >= 48) ? phy_data[63-b] : 1'b0;
    end else begin
      b = 0; e_ck = 1'b0; e_oe = 1'b0; mdi = 1'b0;
    end
    if (rst_n) begin
      chk("R2 serial clock", {31'd0, mck}, {31'd0, e_ck});
      chk(m_rd ? "R5 output enable" : "R10 output enable", {31'd0, moe}, {31'd0, e_oe});
      if (m_busy && e_oe) begin
        if (b < 32) chk("R4 preamble bit", {31'd0, mdo}, 32'd1);
        else        chk("R4 command bit", {31'd0, mdo}, {31'd0, m_cmd[63-b]});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : stim
    logic [31:0] w1, r1, w2, w3, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_chk(2'd0, 32'd0, "R1 cmd reset");
    rd_chk(2'd1, 32'd0, "R1 speed reset");
    rd_chk(2'd2, 32'd0, "R1 event reset");
    rd_chk(2'd3, 32'd0, "R1 unused address");
    chk("R1 clock low", {31'd0, mck}, 32'd0);
    chk("R1 released", {31'd0, moe}, 32'd0);

    // R3 zero speed blocks frames
    wr(2'd0, 32'h6182_0000);
    repeat (20) @(negedge clk);
    chk("R3 clock stays low", {31'd0, mck}, 32'd0);
    chk("R3 no drive", {31'd0, moe}, 32'd0);
    rd_chk(2'd0, 32'h6182_0000, "R3 word stored");
    rd_chk(2'd2, 32'd0, "R3 no event");

    // R2 speed field
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk(2'd1, 32'h0000_007E, "R2 field bits 6:1");
    wr(2'd1, 32'd2 << 1);
    rd_chk(2'd1, 32'd4, "R2 speed readback");

    // R4 / R7 write frame with exact completion timing
    w1 = 32'h5002_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'h0000_A5C3;
    wr(2'd0, w1);
    repeat (128 * 2 - 2) @(negedge clk);
    rd_chk(2'd2, 32'd0, "R7 event not before end");
    rd_chk(2'd2, 32'h0080_0000, "R7 event at end");
    rd_chk(2'd0, w1, "R4 write word kept");

    // R8 write-one-to-clear
    wr(2'd2, 32'hFF7F_FFFF);
    rd_chk(2'd2, 32'h0080_0000, "R8 write zero no effect");
    wr(2'd2, 32'h0080_0000);
    rd_chk(2'd2, 32'd0, "R8 write one clears");

    // R5 / R6 read frame, half period 3
    wr(2'd1, 32'd3 << 1);
    phy_data = 16'hC3A5;
    r1 = 32'h6002_0000 | (32'd17 << 23) | (32'd2 << 18);
    wr(2'd0, r1);
    wait_idle();
    rd_chk(2'd0, {r1[31:16], 16'hC3A5}, "R6 read data captured");
    rd_chk(2'd2, 32'h0080_0000, "R7 event after read");
    wr(2'd2, 32'h0080_0000);

    // R9 writes during a frame
    wr(2'd1, 32'd2 << 1);
    w2 = 32'h5002_0000 | (32'd1 << 23) | (32'd31 << 18) | 32'h0000_0F0F;
    wr(2'd0, w2);
    repeat (30) @(negedge clk);
    wr(2'd0, 32'hDEAD_BEEF);
    wr(2'd1, 32'd5 << 1);
    wait_idle();
    rd_chk(2'd0, w2, "R9 busy command write ignored");
    rd_chk(2'd1, 32'd10, "R9 speed write taken");
    wr(2'd2, 32'h0080_0000);

    // R10 other opcode drives whole frame, half period 5
    w3 = 32'h7ABC_1234;
    wr(2'd0, w3);
    wait_idle();
    rd_chk(2'd0, w3, "R10 word kept");
    chk("R10 released when idle", {31'd0, moe}, 32'd0);
    wr(2'd2, 32'h0080_0000);

    // R6 boundary: half period 1, back-to-back reads
    wr(2'd1, 32'd1 << 1);
    phy_data = 16'h8001;
    r2 = 32'h6002_0000 | (32'd31 << 18);
    wr(2'd0, r2);
    wait_idle();
    rd_chk(2'd0, {r2[31:16], 16'h8001}, "R6 capture at half period 1");
    phy_data = 16'h7FFE;
    wr(2'd0, r2 | (32'd9 << 23));
    wait_idle();
    rd_chk(2'd0, {r2[31:16] | 16'h0480, 16'h7FFE}, "R6 second read");
    wr(2'd2, 32'h0080_0000);

    // R2 boundary: largest half period
    wr(2'd1, 32'd63 << 1);
    rd_chk(2'd1, 32'd126, "R2 max speed readback");
    wr(2'd0, w1);
    wait_idle();
    rd_chk(2'd2, 32'h0080_0000, "R7 event at max period");
    rd_chk(2'd0, w1, "R4 word after slow frame");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule